// File: doc/BRIEF.md
# Infrared Transmit Modulator with Receive Conditioner

This block forms the infrared optical port's output pin. A two-bit source select picks the signal sent to the line: UART transmit data, a general-purpose output bit, or one of two energy pulse signals. An optional inversion follows the selection. An optional modulation stage then replaces every low period of the line with a square carrier. The carrier is built from a phase counter that advances on an external tick strobe. The fraction of each carrier period spent low is programmable.

The receive side takes the optical comparator result and the pin's digital input. It forwards one of them, depending on whether the pin serves as the UART receive input or as a plain digital input. The configuration fields come in as inputs, from a register bank elsewhere. Carrier frequency synthesis, the UART and the analog comparator sit outside this block.

Top module: `irtx_top`

## Requirements
- R1: The pin source follows `src_sel`: 2'b00 selects `uart_txd`, 2'b01 selects `gpo_bit`, 2'b10 selects `pulse_a`, 2'b11 selects `pulse_b`.
- R2: When `tx_inv` is 1, the selected source is inverted. The inversion happens before the modulation stage.
- R3: With `mod_en` at 0, `ir_tx_o` equals the post-inversion line value from the previous clock cycle.
- R4: With `mod_en` at 1 and the post-inversion line at 1, `ir_tx_o` is 1 in the next cycle.
- R5: With `mod_en` at 1 and the post-inversion line at 0, `ir_tx_o` carries the carrier. The carrier is low while the phase counter (0 to 2^PHASE_W-1) is below a threshold and high otherwise. The threshold is half, a quarter, an eighth or a sixteenth of 2^PHASE_W, for `duty_sel` values 00, 01, 10 and 11 in that order.
- R6: A new `duty_sel` value takes effect only at a carrier period boundary. It is latched on the tick that wraps the phase counter from its maximum back to 0.
- R7: The phase counter advances by one on each cycle where `carrier_tick` is 1 and holds its value on all other cycles.
- R8: With `rx_dis` at 0, `uart_rxd_o` equals `rx_comp` XOR `rx_inv` one cycle later, and `dio_rx_o` is 0.
- R9: With `rx_dis` at 1, `uart_rxd_o` is 1 (idle) and `dio_rx_o` equals `rx_pad` one cycle later. `rx_inv` has no effect on either output.
- R10: While `rst_n` is low, `ir_tx_o` is 1, `uart_rxd_o` is 1, `dio_rx_o` is 0, the phase counter is 0 and the latched duty is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_tick | input | 1 | Strobe that advances the carrier phase |
| src_sel | input | 2 | Source select for the pin |
| tx_inv | input | 1 | Invert the selected source |
| mod_en | input | 1 | Enable carrier modulation of low periods |
| duty_sel | input | 2 | Carrier low-fraction select |
| uart_txd | input | 1 | UART transmit data |
| gpo_bit | input | 1 | General-purpose output bit |
| pulse_a | input | 1 | First energy pulse |
| pulse_b | input | 1 | Second energy pulse |
| rx_dis | input | 1 | 1: receive pin used as digital input |
| rx_inv | input | 1 | Invert comparator result to UART |
| rx_comp | input | 1 | Optical comparator result |
| rx_pad | input | 1 | Digital input from the receive pin |
| ir_tx_o | output | 1 | Registered transmit pin output |
| uart_rxd_o | output | 1 | Conditioned UART receive bit |
| dio_rx_o | output | 1 | Digital input value from receive pin |

## Verification
The bench uses the default PHASE_W of 4, so one carrier period is 16 ticks. A period boundary therefore comes every few dozen cycles, and the bench crosses it many times. It also measures each of the four low fractions exactly over a 16-tick window (8, 4, 2 and 1 low ticks). The small period lets a duty change be placed at a known phase in mid-period, where the old and new thresholds give different pin values. A long random run mixes gaps in the tick with changes to the source and modulation settings.

// File: rtl/irtx_pkg.sv
// Package irtx_pkg
// Shared types for the infrared transmit modulator.
// Assumes: the source select is a 2-bit field whose code order is fixed.
package irtx_pkg;

    typedef enum logic [1:0] {
        SRC_UART    = 2'b00,
        SRC_GPO     = 2'b01,
        SRC_PULSE_A = 2'b10,
        SRC_PULSE_B = 2'b11
    } src_sel_e;

    localparam int unsigned DUTY_CODES = 4;

endpackage

// File: rtl/irtx_carrier.sv
// Module irtx_carrier
// Produces the modulation carrier. A phase counter advances on each tick.
// The carrier is low while the phase is below a threshold taken from the
// latched duty code. The duty code is latched only when the phase wraps,
// so a period never mixes two duty settings.
// Assumes: PHASE_W >= 4, so that the smallest fraction (1/16) is at least
// one step.
module irtx_carrier #(
    parameter int unsigned PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [1:0]         duty_sel,
    output logic               carrier_low,
    output logic [PHASE_W-1:0] phase,
    output logic [1:0]         duty_act
);
    import irtx_pkg::*;

    localparam int unsigned         STEPS     = 1 << PHASE_W;
    localparam logic [PHASE_W-1:0]  PHASE_MAX = PHASE_W'(STEPS - 1);

    logic [PHASE_W-1:0] phase_q;
    logic [1:0]         duty_q;
    logic [PHASE_W:0]   thr_tab [DUTY_CODES];
    logic               wrap;

    // Threshold per duty code: 1/2, 1/4, 1/8, 1/16 of the period.
    for (genvar k = 0; k < DUTY_CODES; k++) begin : g_thr
        assign thr_tab[k] = (PHASE_W+1)'(STEPS >> (k + 1));
    end

    // The period ends on the tick taken at the maximum phase.
    assign wrap = tick && (phase_q == PHASE_MAX);

    // Advance the phase counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= phase_q + PHASE_W'(1);
    end

    // Latch a new duty code only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    duty_q <= 2'b00;
        else if (wrap) duty_q <= duty_sel;
    end

    // Carrier low while the phase is below the active threshold.
    always_comb begin
        carrier_low = ({1'b0, phase_q} < thr_tab[duty_q]);
    end

    assign phase    = phase_q;
    assign duty_act = duty_q;

endmodule

// File: rtl/irtx_txpath.sv
// Module irtx_txpath
// Transmit line: source selection, then optional inversion, then optional
// carrier on low periods, then one output register.
// Assumes: carrier_low is already synchronous to clk.
module irtx_txpath (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       tx_inv,
    input  logic       mod_en,
    input  logic       uart_txd,
    input  logic       gpo_bit,
    input  logic       pulse_a,
    input  logic       pulse_b,
    input  logic       carrier_low,
    output logic       line_post,
    output logic       pin_o
);
    import irtx_pkg::*;

    src_sel_e sel_e;
    logic     sel_bit;
    logic     pin_d;
    logic     pin_q;

    assign sel_e = src_sel_e'(src_sel);

    // Pick the source signal for the line.
    always_comb begin
        unique case (sel_e)
            SRC_UART:    sel_bit = uart_txd;
            SRC_GPO:     sel_bit = gpo_bit;
            SRC_PULSE_A: sel_bit = pulse_a;
            SRC_PULSE_B: sel_bit = pulse_b;
            default:     sel_bit = uart_txd;
        endcase
    end

    // Optional inversion ahead of modulation.
    assign line_post = sel_bit ^ tx_inv;

    // Put the carrier on the line only where it would otherwise be low.
    always_comb begin
        if (mod_en && !line_post) pin_d = !carrier_low;
        else                      pin_d = line_post;
    end

    // Register the pin; it idles high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;

endmodule

// File: rtl/irtx_rxcond.sv
// Module irtx_rxcond
// Receive conditioner. In UART mode it forwards the comparator result,
// optionally inverted. In digital mode the UART input is held idle high,
// and the pad value is passed on with no inversion.
// Assumes: rx_comp and rx_pad are already synchronized by the caller.
module irtx_rxcond (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_dis,
    input  logic rx_inv,
    input  logic rx_comp,
    input  logic rx_pad,
    output logic uart_rxd,
    output logic dio_rx
);
    logic uart_d;
    logic dio_d;
    logic uart_q;
    logic dio_q;

    // Route the pin to the UART or to the digital input.
    always_comb begin
        if (rx_dis) begin
            uart_d = 1'b1;
            dio_d  = rx_pad;
        end else begin
            uart_d = rx_comp ^ rx_inv;
            dio_d  = 1'b0;
        end
    end

    // Register both receive outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uart_q <= 1'b1;
            dio_q  <= 1'b0;
        end else begin
            uart_q <= uart_d;
            dio_q  <= dio_d;
        end
    end

    assign uart_rxd = uart_q;
    assign dio_rx   = dio_q;

endmodule

// File: rtl/irtx_top.sv
// Module irtx_top
// Infrared port conditioner: transmit modulator plus receive conditioner.
// Assumes: all configuration fields come from a register bank that resets
// them to 0; carrier_tick is a one-cycle strobe at the carrier step rate.
module irtx_top #(
    parameter int unsigned PHASE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier_tick,
    input  logic [1:0] src_sel,
    input  logic       tx_inv,
    input  logic       mod_en,
    input  logic [1:0] duty_sel,
    input  logic       uart_txd,
    input  logic       gpo_bit,
    input  logic       pulse_a,
    input  logic       pulse_b,
    input  logic       rx_dis,
    input  logic       rx_inv,
    input  logic       rx_comp,
    input  logic       rx_pad,
    output logic       ir_tx_o,
    output logic       uart_rxd_o,
    output logic       dio_rx_o
);
    logic               carrier_low;
    logic [PHASE_W-1:0] car_phase;
    logic [1:0]         car_duty;
    logic               line_post;

    irtx_carrier #(.PHASE_W(PHASE_W)) carrier_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (carrier_tick),
        .duty_sel    (duty_sel),
        .carrier_low (carrier_low),
        .phase       (car_phase),
        .duty_act    (car_duty)
    );

    irtx_txpath txpath_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_sel     (src_sel),
        .tx_inv      (tx_inv),
        .mod_en      (mod_en),
        .uart_txd    (uart_txd),
        .gpo_bit     (gpo_bit),
        .pulse_a     (pulse_a),
        .pulse_b     (pulse_b),
        .carrier_low (carrier_low),
        .line_post   (line_post),
        .pin_o       (ir_tx_o)
    );

    irtx_rxcond rxcond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_dis   (rx_dis),
        .rx_inv   (rx_inv),
        .rx_comp  (rx_comp),
        .rx_pad   (rx_pad),
        .uart_rxd (uart_rxd_o),
        .dio_rx   (dio_rx_o)
    );

endmodule

// File: rtl/irtx_chk.sv
// Module irtx_chk
// Checker bound to irtx_top. It relates the pin and receive outputs to
// their inputs and internal state over time.
// Assumes: it is attached through the bind statement below.
module irtx_chk #(
    parameter int unsigned PHASE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               carrier_tick,
    input logic               mod_en,
    input logic               rx_dis,
    input logic               rx_inv,
    input logic               rx_comp,
    input logic               rx_pad,
    input logic               line_post,
    input logic [PHASE_W-1:0] phase,
    input logic [1:0]         duty_act,
    input logic               ir_tx_o,
    input logic               uart_rxd_o,
    input logic               dio_rx_o
);
    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (ir_tx_o == $past(line_post)));

    // R4
    mark_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && line_post) |=> ir_tx_o);

    // R6
    duty_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act != $past(duty_act)) |-> (phase == '0));

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_tick |=> $stable(phase));

    // R8
    rx_uart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dis |=> (uart_rxd_o == $past(rx_comp ^ rx_inv)) && !dio_rx_o);

    // R9
    rx_dio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dis |=> uart_rxd_o && (dio_rx_o == $past(rx_pad)));

endmodule

bind irtx_top irtx_chk #(.PHASE_W(PHASE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_tick (carrier_tick),
    .mod_en       (mod_en),
    .rx_dis       (rx_dis),
    .rx_inv       (rx_inv),
    .rx_comp      (rx_comp),
    .rx_pad       (rx_pad),
    .line_post    (line_post),
    .phase        (car_phase),
    .duty_act     (car_duty),
    .ir_tx_o      (ir_tx_o),
    .uart_rxd_o   (uart_rxd_o),
    .dio_rx_o     (dio_rx_o)
);

// File: tb/irtx_top_tb_top.sv
`timescale 1ns/1ps
module irtx_top_tb_top;
    localparam int unsigned PHASE_W = 4;
    localparam int unsigned STEPS   = 1 << PHASE_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier_tick = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       tx_inv = 1'b0;
    logic       mod_en = 1'b0;
    logic [1:0] duty_sel = 2'b00;
    logic       uart_txd = 1'b1;
    logic       gpo_bit = 1'b0;
    logic       pulse_a = 1'b0;
    logic       pulse_b = 1'b0;
    logic       rx_dis = 1'b0;
    logic       rx_inv = 1'b0;
    logic       rx_comp = 1'b0;
    logic       rx_pad = 1'b0;
    logic       ir_tx_o;
    logic       uart_rxd_o;
    logic       dio_rx_o;

    int total = 0;
    int bad   = 0;

    logic [PHASE_W-1:0] m_phase = '0;
    logic [1:0]         m_duty  = 2'b00;

    always #2.5 clk = ~clk;

    irtx_top #(.PHASE_W(PHASE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick),
        .src_sel(src_sel), .tx_inv(tx_inv), .mod_en(mod_en),
        .duty_sel(duty_sel), .uart_txd(uart_txd), .gpo_bit(gpo_bit),
        .pulse_a(pulse_a), .pulse_b(pulse_b), .rx_dis(rx_dis),
        .rx_inv(rx_inv), .rx_comp(rx_comp), .rx_pad(rx_pad),
        .ir_tx_o(ir_tx_o), .uart_rxd_o(uart_rxd_o), .dio_rx_o(dio_rx_o)
    );

    // Line value after source selection and inversion (R1, R2).
    function automatic logic line_model();
        logic s;
        case (src_sel)
            2'b00:   s = uart_txd;
            2'b01:   s = gpo_bit;
            2'b10:   s = pulse_a;
            default: s = pulse_b;
        endcase
        return s ^ tx_inv;
    endfunction

    // Pin value the design registers on the coming edge (R3, R4, R5).
    function automatic logic pin_model();
        logic ln = line_model();
        int unsigned thr = STEPS >> (int'(m_duty) + 1);
        if (mod_en && !ln) return !(int'(m_phase) < int'(thr));
        return ln;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One clock cycle with every output checked afterwards.
    task automatic cyc(input string req);
        logic ep  = pin_model();
        logic eu  = rx_dis ? 1'b1 : (rx_comp ^ rx_inv);
        logic ed  = rx_dis ? rx_pad : 1'b0;
        string rr = rx_dis ? "R9" : "R8";
        @(posedge clk);
        if (carrier_tick) begin
            if (m_phase == PHASE_W'(STEPS - 1)) m_duty = duty_sel;
            m_phase = m_phase + PHASE_W'(1);
        end
        @(negedge clk);
        check(req, ir_tx_o, ep);
        check(rr, uart_rxd_o, eu);
        check(rr, dio_rx_o, ed);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lows;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 pin", ir_tx_o, 1'b1);
        check("R10 uart", uart_rxd_o, 1'b1);
        check("R10 dio", dio_rx_o, 1'b0);
        rst_n = 1'b1;

        // R1 each source, the others driven opposite
        for (int s = 0; s < 4; s++) begin
            src_sel  = 2'(s);
            uart_txd = (s == 0); gpo_bit = (s == 1);
            pulse_a  = (s == 2); pulse_b = (s == 3);
            cyc("R1 sel high");
            uart_txd = !(s == 0); gpo_bit = !(s == 1);
            pulse_a  = !(s == 2); pulse_b = !(s == 3);
            cyc("R1 sel low");
        end
        // R2 inversion with modulation off
        src_sel = 2'b01; gpo_bit = 1'b1; tx_inv = 1'b1;
        cyc("R2 inv");
        check("R2 inv pin", ir_tx_o, 1'b0);
        tx_inv = 1'b0;
        cyc("R3 passthru");

        // R5 low fraction of each duty code, tick every cycle
        mod_en = 1'b1; src_sel = 2'b00; uart_txd = 1'b0; carrier_tick = 1'b1;
        for (int d = 0; d < 4; d++) begin
            duty_sel = 2'(d);
            repeat (2 * STEPS) cyc("R5 settle");
            lows = 0;
            for (int i = 0; i < int'(STEPS); i++) begin
                cyc("R5 carrier");
                if (!ir_tx_o) lows++;
            end
            total++;
            if (lows != int'(STEPS >> (d + 1))) begin
                bad++;
                $display("FAIL R5 duty %0d: actual=%0d expected=%0d",
                         d, lows, STEPS >> (d + 1));
            end
        end

        // R6 change duty in mid-period: old 50% still applies at phase 3
        duty_sel = 2'b00;
        repeat (2 * STEPS) cyc("R6 settle");
        while (m_phase != PHASE_W'(2)) cyc("R6 align");
        duty_sel = 2'b11;
        cyc("R6 mid");
        check("R6 old duty kept", ir_tx_o, 1'b0);
        repeat (2 * STEPS) cyc("R6 after boundary");

        // R7 no ticks: phase holds, pin keeps its level
        carrier_tick = 1'b0;
        repeat (6) cyc("R7 hold");
        carrier_tick = 1'b1;

        // R4 line high under modulation
        uart_txd = 1'b1;
        repeat (STEPS) cyc("R4 mark");

        // R8 / R9 receive paths, with rx_inv toggled in both modes
        for (int k = 0; k < 16; k++) begin
            rx_dis = k[3]; rx_inv = k[0]; rx_comp = k[1]; rx_pad = k[2];
            cyc(rx_dis ? "R9 rx" : "R8 rx");
        end

        // Random mix of all inputs
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] r = 16'($urandom);
            carrier_tick = r[0] | r[1];
            src_sel  = r[3:2];  tx_inv = r[4];  mod_en = r[5] | r[6];
            if (r[15:12] == 4'h0) duty_sel = r[8:7];
            uart_txd = r[9]; gpo_bit = r[10]; pulse_a = r[11]; pulse_b = r[12];
            rx_dis = r[13]; rx_inv = r[14]; rx_comp = r[15]; rx_pad = r[1];
            cyc("R1 R2 R3 R4 R5 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule